// File: doc/BRIEF.md
# Left-Right Position Tracker

This block keeps a position within a range of nine steps, numbered 0 to 8, in a small loadable up/down counter. Two request inputs move the position. One asks for a step toward the low end and one asks for a step toward the high end. The position moves by at most one step per clock. It never leaves the range.

When the position sits at either end, an indicator output for that end is high. A request toward that end is then ignored, while a request away from it is still honoured. A synchronous reset puts the position back to the centre value 4.

Typical use is a simple left/right selector: a marker that the user steers with two buttons. The buttons must be debounced and edge-reduced upstream.

Top module: `lr_pos_tracker`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pos` becomes 4 after that edge, whatever `step_left` and `step_right` are doing.
- R2: With `step_right`=1, `step_left`=0 and `pos` below 8, `pos` increases by exactly one at each edge.
- R3: With `step_left`=1, `step_right`=0 and `pos` above 0, `pos` decreases by exactly one at each edge.
- R4: With both request inputs low and `rst` low, `pos` keeps its value.
- R5: With both request inputs high, the high-direction request wins. `pos` rises by one below 8 and stays at 8 when already there.
- R6: `led_right` is 1 exactly when `pos` is 8. A high-direction request at 8 leaves `pos` at 8.
- R7: `led_left` is 1 exactly when `pos` is 0. A low-direction request at 0 leaves `pos` at 0.
- R8: `pos` never takes a value above 8, and `led_left` and `led_right` are never both 1.
- R9: From 8, a low-direction request moves `pos` to 7. From 0, a high-direction request moves `pos` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, loads the centre position |
| step_left | input | 1 | Request one step toward position 0 |
| step_right | input | 1 | Request one step toward position 8, wins over `step_left` |
| led_left | output | 1 | High while the position is 0 |
| led_right | output | 1 | High while the position is 8 |
| pos | output | 4 | Current position, 0 to 8 |

## Verification
The properties assume that `rst` is high at the first clock edge, so the counter starts from a defined value before any step property is evaluated. They also assume that the request inputs are stable around each edge. The bench meets both conditions: it holds reset for the first edges, and it changes inputs only one nanosecond after a rising edge. Beyond the directed walks to both ends, a pseudo-random phase drives every combination of the two requests. It also fires an occasional reset in the middle of a run, so that the assumptions hold while the inputs still reach all four combinations.

// File: rtl/lr_pkg.sv
package lr_pkg;

    // Decision taken by the step arbiter for one clock.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/lr_end_detect.sv
module lr_end_detect #(
    parameter int W       = 4,
    parameter int MAX_POS = 8
) (
    input  logic [W-1:0] cnt,
    output logic         at_lo,
    output logic         at_hi
);

    localparam logic [W-1:0] LoVal = '0;
    localparam logic [W-1:0] HiVal = W'(MAX_POS);

    always_comb begin
        at_lo = (cnt == LoVal);
        at_hi = (cnt == HiVal);
    end

endmodule

// File: rtl/lr_step_arb.sv
module lr_step_arb
    import lr_pkg::*;
(
    input  logic step_left,
    input  logic step_right,
    input  logic at_lo,
    input  logic at_hi,
    output logic en,
    output logic up
);

    step_e step;

    // The high-direction request owns the direction; an end stop blocks only its own direction.
    always_comb begin
        step = STEP_HOLD;
        if (step_right) begin
            if (!at_hi) step = STEP_UP;
        end else if (step_left) begin
            if (!at_lo) step = STEP_DOWN;
        end
        en = (step != STEP_HOLD);
        up = (step == STEP_UP);
    end

endmodule

// File: rtl/lr_pos_counter.sv
module lr_pos_counter #(
    parameter int            W        = 4,
    parameter logic [W-1:0]  LOAD_VAL = '0
) (
    input  logic         clk,
    input  logic         load,
    input  logic         en,
    input  logic         up,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.cnt = LOAD_VAL;
        end else if (en) begin
            if (up) state_d.cnt = state_q.cnt + W'(1);
            else    state_d.cnt = state_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q = state_q.cnt;

endmodule

// File: rtl/lr_pos_tracker.sv
module lr_pos_tracker #(
    parameter int NUM_POS = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step_left,
    input  logic                       step_right,
    output logic                       led_left,
    output logic                       led_right,
    output logic [$clog2(NUM_POS)-1:0] pos
);

    localparam int CtrW   = $clog2(NUM_POS);
    localparam int MaxPos = NUM_POS - 1;
    localparam logic [CtrW-1:0] Centre = CtrW'(MaxPos / 2);

    logic [CtrW-1:0] cnt;
    logic            at_lo, at_hi;
    logic            en, up;

    lr_end_detect #(
        .W       (CtrW),
        .MAX_POS (MaxPos)
    ) u_ends (
        .cnt   (cnt),
        .at_lo (at_lo),
        .at_hi (at_hi)
    );

    lr_step_arb u_arb (
        .step_left  (step_left),
        .step_right (step_right),
        .at_lo      (at_lo),
        .at_hi      (at_hi),
        .en         (en),
        .up         (up)
    );

    lr_pos_counter #(
        .W        (CtrW),
        .LOAD_VAL (Centre)
    ) u_ctr (
        .clk  (clk),
        .load (rst),
        .en   (en),
        .up   (up),
        .q    (cnt)
    );

    assign pos       = cnt;
    assign led_left  = at_lo;
    assign led_right = at_hi;

endmodule

// File: rtl/lr_pos_tracker_chk.sv
module lr_pos_tracker_chk #(
    parameter int NUM_POS = 9
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       step_left,
    input logic                       step_right,
    input logic                       led_left,
    input logic                       led_right,
    input logic [$clog2(NUM_POS)-1:0] pos
);

    localparam int CtrW = $clog2(NUM_POS);
    localparam logic [CtrW-1:0] MaxV = CtrW'(NUM_POS - 1);
    localparam logic [CtrW-1:0] MidV = CtrW'((NUM_POS - 1) / 2);

    assert_reset_centre_R1: assert property (@(posedge clk)
        rst |=> pos == MidV);

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (step_right && !step_left && pos != MaxV) |=> pos == $past(pos) + CtrW'(1));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (step_left && !step_right && pos != '0) |=> pos == $past(pos) - CtrW'(1));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!step_left && !step_right) |=> $stable(pos));

    assert_both_up_R5: assert property (@(posedge clk) disable iff (rst)
        (step_left && step_right && pos != MaxV) |=> pos == $past(pos) + CtrW'(1));

    assert_hi_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (step_right && pos == MaxV) |=> (pos == MaxV && led_right));

    assert_lo_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (step_left && !step_right && pos == '0) |=> (pos == '0 && led_left));

    assert_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        (pos <= MaxV) && $onehot0({led_left, led_right}));

    assert_leave_end_R9: assert property (@(posedge clk) disable iff (rst)
        (step_left && !step_right && led_right) |=> (!led_right && !led_left));

endmodule

bind lr_pos_tracker lr_pos_tracker_chk #(.NUM_POS(NUM_POS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_left  (step_left),
    .step_right (step_right),
    .led_left   (led_left),
    .led_right  (led_right),
    .pos        (pos)
);

// File: tb/lr_pos_tracker_tb.sv
module lr_pos_tracker_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_left = 1'b0;
    logic       step_right = 1'b0;
    logic       led_left, led_right;
    logic [3:0] pos;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 4;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    lr_pos_tracker u_dut (
        .clk        (clk),
        .rst        (rst),
        .step_left  (step_left),
        .step_right (step_right),
        .led_left   (led_left),
        .led_right  (led_right),
        .pos        (pos)
    );

    // One clock: apply inputs, advance the model, sample 1 ns after the edge.
    task automatic cyc(input logic l, input logic r, input logic s, input string tag);
        logic exp_lo, exp_hi;
        step_left  = l;
        step_right = r;
        rst        = s;
        if (s)                  model = 4;
        else if (r)             model = (model < 8) ? model + 1 : model;
        else if (l)             model = (model > 0) ? model - 1 : model;
        exp_lo = (model == 0);
        exp_hi = (model == 8);
        @(posedge clk);
        #1;
        n_checks++;
        if (int'(pos) != model || led_left !== exp_lo || led_right !== exp_hi) begin
            n_fail++;
            $display("FAIL %s: pos=%0d led_left=%0b led_right=%0b, expected pos=%0d led_left=%0b led_right=%0b",
                     tag, pos, led_left, led_right, model, exp_lo, exp_hi);
        end
    endtask

    initial begin
        // R1: reset overrides both requests
        cyc(1, 1, 1, "R1");
        cyc(1, 0, 1, "R1");
        // R4: idle holds
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R4");
        // R2 then R6: walk up and saturate
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R6");
        // R9: leave the high end
        cyc(1, 0, 0, "R9");
        // R3 then R7: walk down and saturate
        for (int i = 0; i < 7; i++) cyc(1, 0, 0, "R3");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R7");
        cyc(0, 0, 0, "R4");
        // R9: leave the low end
        cyc(0, 1, 0, "R9");
        // R5: both high, right wins, then at the top end holds
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, "R5");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, "R2");
        for (int i = 0; i < 2; i++) cyc(1, 1, 0, "R5");
        // R1: reset in mid-run with a request held
        cyc(0, 1, 1, "R1");
        // R8: pseudo-random mix with occasional reset
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr[1] & lfsr[2], (lfsr[7:3] == 5'd0), "R8");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule